// File: doc/BRIEF.md
# Triangular code ramp generator

This block produces a stream of converter codes for linearity sweeps. The code rises from a programmed lower limit to a programmed upper limit in programmed increments, then falls back to the lower limit, and repeats. The result is a triangle wave in code space. The block runs on a divided copy of the converter output clock.

Each code stays on the output for a programmable number of clock cycles. This lets slow measurement equipment settle on every code before the next one arrives. A one-cycle strobe accompanies every code update.

When a step would carry the code beyond a limit, the code is set to that limit, and the next update moves in the opposite direction. While the enable input is low, the output holds the lower limit and the next sweep starts upward.

Top module: `tri_ramp_gen`

## Requirements
- R1: While rst_ni is low, code_o is 0 and new_code_o is 0.
- R2: In each cycle after a clock edge with en_i low, code_o equals the lo_i value sampled at that edge, and new_code_o is 0. The first update after en_i rises moves upward.
- R3: While en_i is high, each code stays on code_o for exactly max(dwell_i, 1) cycles. code_o changes only in the cycle in which new_code_o is 1, and new_code_o is 1 for one cycle per update. With a constant en_i high, the first update comes max(dwell_i, 1) cycles after en_i is first sampled high.
- R4: Moving upward, when hi_i - code_o > step_i, an update sets code_o to code_o + step_i.
- R5: Moving upward, when the code would reach or pass hi_i, an update sets code_o to hi_i. The update after that moves downward. This never wraps past the top of the code range.
- R6: Moving downward, when code_o - lo_i > step_i, an update sets code_o to code_o - step_i. Otherwise an update sets code_o to lo_i, and the update after that moves upward.
- R7: When lo_i equals hi_i, code_o stays at that value across all updates.
- R8: When step_i is 0, code_o stays at lo_i across all updates.
- R9: A dwell_i of 0 behaves as a dwell of 1: the code updates on every enabled cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Divided converter output clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Sweep enable; low holds the code at the lower limit |
| lo_i | input | CODE_W | Lower sweep limit |
| hi_i | input | CODE_W | Upper sweep limit |
| step_i | input | CODE_W | Code increment per update |
| dwell_i | input | DWELL_W | Cycles each code is held (0 counts as 1) |
| code_o | output | CODE_W | Current converter code |
| new_code_o | output | 1 | One-cycle pulse when code_o takes an updated value |

## Verification
The sweep is tried with four kinds of step:
- A step that does not divide the span. This shows clamping at both limits, as distinct from plain stepping.
- A step that divides the span exactly. This shows that a limit reached exactly is not visited twice.
- A large step near the top of the code range. This would expose a wrap-around in the limit comparison.
- A zero step. This shows that the code stays constant.

Dwell values of 0, 1, 2 and 5 separate the hold rule from an off-by-one in the counter. An equal-limits case shows that the output stays flat. Disabling between runs with a new lower limit shows that the disabled code reload and the restart direction work.

// File: rtl/tri_ramp_pkg.sv
package tri_ramp_pkg;
  typedef enum logic {
    DIR_UP = 1'b0,
    DIR_DN = 1'b1
  } ramp_dir_e;
endpackage

// File: rtl/ramp_dwell_timer.sv
module ramp_dwell_timer #(
  parameter int unsigned DWELL_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [DWELL_W-1:0] dwell_i,
  output logic               tick_o
);
  logic [DWELL_W-1:0] cnt_q;
  logic [DWELL_W-1:0] last;
  logic               past_valid_q;

  // zero dwell collapses to a one-cycle hold
  assign last   = (dwell_i == '0) ? '0 : dwell_i - 1'b1;
  assign tick_o = en_i && (cnt_q >= last);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (!en_i || tick_o) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_valid_q <= 1'b0;
    else         past_valid_q <= 1'b1;
  end

  // R3: counter never runs past the hold length while it is stable
  p_cnt_bound_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_valid_q && en_i && $past(en_i) && $stable(dwell_i)) |-> (cnt_q <= last));

  // R9: zero dwell ticks on every enabled cycle
  p_zero_dwell_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && dwell_i == '0) |-> tick_o);
endmodule

// File: rtl/ramp_step_calc.sv
module ramp_step_calc
  import tri_ramp_pkg::*;
#(
  parameter int unsigned CODE_W = 11
) (
  input  logic [CODE_W-1:0] code_i,
  input  ramp_dir_e         dir_i,
  input  logic [CODE_W-1:0] lo_i,
  input  logic [CODE_W-1:0] hi_i,
  input  logic [CODE_W-1:0] step_i,
  output logic [CODE_W-1:0] next_code_o,
  output ramp_dir_e         next_dir_o
);
  logic hit_hi;
  logic hit_lo;

  // remaining-headroom compare avoids wrap at the top of the range
  assign hit_hi = (code_i >= hi_i) || ((hi_i - code_i) <= step_i);
  assign hit_lo = (code_i <= lo_i) || ((code_i - lo_i) <= step_i);

  always_comb begin
    next_code_o = code_i;
    next_dir_o  = dir_i;
    if (dir_i == DIR_UP) begin
      if (hit_hi) begin
        next_code_o = hi_i;
        next_dir_o  = DIR_DN;
      end else begin
        next_code_o = code_i + step_i;
      end
    end else begin
      if (hit_lo) begin
        next_code_o = lo_i;
        next_dir_o  = DIR_UP;
      end else begin
        next_code_o = code_i - step_i;
      end
    end
  end
endmodule

// File: rtl/tri_ramp_gen.sv
module tri_ramp_gen
  import tri_ramp_pkg::*;
#(
  parameter int unsigned CODE_W  = 11,
  parameter int unsigned DWELL_W = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               en_i,
  input  logic [CODE_W-1:0]  lo_i,
  input  logic [CODE_W-1:0]  hi_i,
  input  logic [CODE_W-1:0]  step_i,
  input  logic [DWELL_W-1:0] dwell_i,
  output logic [CODE_W-1:0]  code_o,
  output logic               new_code_o
);
  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] next_code;
  ramp_dir_e         dir_q;
  ramp_dir_e         next_dir;
  logic              strobe_q;
  logic              tick;
  logic              past_valid_q;

  ramp_dwell_timer #(.DWELL_W(DWELL_W)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .dwell_i (dwell_i),
    .tick_o  (tick)
  );

  ramp_step_calc #(.CODE_W(CODE_W)) u_step (
    .code_i      (code_q),
    .dir_i       (dir_q),
    .lo_i        (lo_i),
    .hi_i        (hi_i),
    .step_i      (step_i),
    .next_code_o (next_code),
    .next_dir_o  (next_dir)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q   <= '0;
      dir_q    <= DIR_UP;
      strobe_q <= 1'b0;
    end else if (!en_i) begin
      code_q   <= lo_i;
      dir_q    <= DIR_UP;
      strobe_q <= 1'b0;
    end else if (tick) begin
      code_q   <= next_code;
      dir_q    <= next_dir;
      strobe_q <= 1'b1;
    end else begin
      strobe_q <= 1'b0;
    end
  end

  assign code_o     = code_q;
  assign new_code_o = strobe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_valid_q <= 1'b0;
    else         past_valid_q <= 1'b1;
  end

  // R1
  p_reset_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (code_o == '0 && !new_code_o));

  // R2
  p_disabled_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_valid_q && $past(!en_i)) |-> (code_o == $past(lo_i) && !new_code_o));

  // R3
  p_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_valid_q && $past(en_i) && !new_code_o) |-> (code_o == $past(code_o)));

  // R3
  p_strobe_en_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_valid_q && new_code_o) |-> $past(en_i));

  // R4
  p_step_up_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_valid_q && new_code_o && $past(dir_q == DIR_UP) && $past(code_o < hi_i)
     && $past((hi_i - code_o) > step_i)) |-> (code_o == $past(code_o + step_i)));

  // R5
  p_clamp_hi_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_valid_q && new_code_o && $past(dir_q == DIR_UP) && $past(code_o <= hi_i)
     && $past((hi_i - code_o) <= step_i)) |-> (code_o == $past(hi_i) && dir_q == DIR_DN));

  // R6
  p_clamp_lo_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_valid_q && new_code_o && $past(dir_q == DIR_DN) && $past(code_o >= lo_i)
     && $past((code_o - lo_i) <= step_i)) |-> (code_o == $past(lo_i) && dir_q == DIR_UP));

  // R7
  p_flat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_valid_q && $past(en_i) && $past(lo_i == hi_i) && $past(code_o == hi_i))
    |-> (code_o == $past(hi_i)));
endmodule

// File: tb/tri_ramp_gen_bench.sv
module tri_ramp_gen_bench;
  localparam int CODE_W  = 11;
  localparam int DWELL_W = 16;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               en = 1'b0;
  logic [CODE_W-1:0]  lo = '0;
  logic [CODE_W-1:0]  hi = '0;
  logic [CODE_W-1:0]  step = '0;
  logic [DWELL_W-1:0] dwell = '0;
  logic [CODE_W-1:0]  code;
  logic               new_code;

  int n_vec = 0;
  int n_bad = 0;
  int cyc   = 0;

  always #2 clk = ~clk;

  tri_ramp_gen #(.CODE_W(CODE_W), .DWELL_W(DWELL_W)) u_tri_ramp_gen (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .en_i       (en),
    .lo_i       (lo),
    .hi_i       (hi),
    .step_i     (step),
    .dwell_i    (dwell),
    .code_o     (code),
    .new_code_o (new_code)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual cycles=%0d expected < 150000", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  task automatic check(input string req, input int act_c, input int exp_c,
                       input int act_s, input int exp_s);
    n_vec++;
    if (act_c != exp_c || act_s != exp_s) begin
      n_bad++;
      $display("FAIL %s: actual code=%0d strobe=%0d expected code=%0d strobe=%0d",
               req, act_c, act_s, exp_c, exp_s);
    end
  endtask

  task automatic ref_next(input int c, input int d, input int l, input int h, input int s,
                          output int nc, output int nd);
    if (d == 0) begin
      if (c >= h || h - c <= s) begin nc = h; nd = 1; end
      else begin nc = c + s; nd = 0; end
    end else begin
      if (c <= l || c - l <= s) begin nc = l; nd = 0; end
      else begin nc = c - s; nd = 1; end
    end
  endtask

  // disable, reload lo, then sweep and compare every cycle
  task automatic run_case(input int l, input int h, input int s, input int dw,
                          input int cycles, input string req);
    int mc, md, mcnt, hold, ms, nc, nd;
    en = 1'b0; lo = l[CODE_W-1:0]; hi = h[CODE_W-1:0];
    step = s[CODE_W-1:0]; dwell = dw[DWELL_W-1:0];
    @(posedge clk); @(negedge clk);
    check("R2 disabled", int'(code), l, int'(new_code), 0);
    en = 1'b1;
    mc = l; md = 0; mcnt = 0; hold = (dw == 0) ? 1 : dw;
    for (int i = 0; i < cycles; i++) begin
      @(posedge clk);
      if (mcnt == hold - 1) begin
        ref_next(mc, md, l, h, s, nc, nd);
        mc = nc; md = nd; mcnt = 0; ms = 1;
      end else begin
        mcnt++; ms = 0;
      end
      @(negedge clk);
      check(req, int'(code), mc, int'(new_code), ms);
    end
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 reset", int'(code), 0, int'(new_code), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R2 after reset", int'(code), 0, int'(new_code), 0);
  endtask

  task automatic t_clamp_both;     run_case(2, 10, 3, 2, 40, "R3 R4 R5 R6 clamp"); endtask
  task automatic t_exact_fit;      run_case(0, 12, 4, 1, 30, "R4 R5 R6 exact"); endtask
  task automatic t_zero_dwell;     run_case(5, 9, 1, 0, 20, "R9 dwell0"); endtask
  task automatic t_long_dwell;     run_case(100, 130, 7, 5, 60, "R3 dwell5"); endtask
  task automatic t_flat;           run_case(7, 7, 3, 0, 10, "R7 flat"); endtask
  task automatic t_zero_step;      run_case(20, 40, 0, 1, 10, "R8 step0"); endtask
  task automatic t_top_range;      run_case(1900, 2047, 100, 1, 12, "R5 no wrap"); endtask

  task automatic t_restart;
    // disable mid-sweep, new lower limit, sweep restarts upward
    run_case(50, 60, 4, 1, 5, "R4 pre-stop");
    run_case(30, 60, 4, 1, 4, "R2 restart up");
  endtask

  initial begin
    t_reset();
    t_clamp_both();
    t_exact_fit();
    t_zero_dwell();
    t_long_dwell();
    t_flat();
    t_zero_step();
    t_top_range();
    t_restart();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule